// File: doc/BRIEF.md
# Root hub downstream port status register

This block holds the status and control state of one downstream port of a USB host controller root hub. It keeps four status bits: current connect status, port enable, port suspend and connect status change. Software reaches them through a single address-decoded register. The port's line-state machinery reports events to the block: a device attaching or detaching, the end of a port reset and the end of a resume. The block updates the status bits from those events.

Software issues commands by writing ones to command bits. A zero written to any bit has no effect. The block checks each command against the current connect status before acting on it. An enable request or a suspend request made while no device is attached does not enable or suspend the port. A suspend request on an empty port instead raises the connect status change flag, so that the driver learns a suspend was attempted with no device present. Software cannot write the connect status directly. A root hub reset sets the connect status to a per-port configuration input, which marks a device that cannot be removed.

Top module: `rh_port_ctrl`

## Requirements
- R1: After the asynchronous reset every status bit is 0. Status bits can be read at these positions: connect status at bit 0, enable at bit 1, suspend at bit 2 and connect status change at bit 16. All other read bits are 0. The read data is 0 whenever `sel_i` is 0. A write takes effect only when `sel_i` and `we_i` are both 1.
- R2: A rising edge on `connect_i` sets connect status and a falling edge clears it. Every change of `connect_i` sets connect status change. Each of these updates appears on the cycle after the edge is sampled.
- R3: A disconnect, meaning a falling edge on `connect_i`, clears connect status, enable and suspend together on the same cycle.
- R4: Writing 1 to bit 2 while connect status is 1 sets suspend. Writing 0 to bit 2 leaves suspend unchanged.
- R5: Writing 1 to bit 2 while connect status is 0 sets connect status change and leaves suspend at 0.
- R6: Writing 1 to bit 1 sets enable only when connect status is 1. Otherwise that write, and any write of 0, leaves enable unchanged.
- R7: Writing 1 to bit 0 clears enable. No write ever changes connect status.
- R8: A pulse on `port_rst_done_i` clears suspend and sets enable.
- R9: A pulse on `resume_done_i` while suspend is 1 clears suspend and sets enable. While suspend is 0 the pulse is ignored.
- R10: Writing 1 to bit 16 clears connect status change. Writing 0 to bit 16 leaves it unchanged.
- R11: A pulse on `hub_rst_i` sets connect status to `fixed_dev_i` and clears enable, suspend and connect status change.
- R12: When a hardware event and a software write act on the same bit in one cycle, the hardware event decides the result. A disconnect beats an enable or suspend request. A connect change beats a clear of connect status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select from the address decoder |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data, where a 1 in a bit issues that command |
| rdata_o | output | DATA_W | Read data, or 0 when the register is not selected |
| connect_i | input | 1 | Device-present level from the port line-state logic |
| fixed_dev_i | input | 1 | Marks the device on this port as non-removable |
| hub_rst_i | input | 1 | Root hub reset pulse |
| port_rst_done_i | input | 1 | Port reset sequence has completed |
| resume_done_i | input | 1 | Resume sequence has completed |

## Verification
A wrong internal state shows up in the read word on the very next cycle, because the read data is taken straight from the status registers. A stale copy of the connect line shows as a missed or extra change flag one cycle after an edge. A command resolved against the wrong connect status shows as an enable or suspend bit that should have stayed 0. A wrong priority shows only in cycles where a write and an event coincide, so the bench creates such cycles on purpose. It also compares the full read word with a reference model after every clock.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int unsigned CONN_BIT = 0;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned SUSP_BIT = 2;

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic clr_chg;
  } port_cmd_t;

  typedef struct packed {
    logic conn;
    logic en;
    logic susp;
    logic chg;
  } port_stat_t;
endpackage

// File: rtl/rh_port_cmd.sv
module rh_port_cmd
  import rh_port_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHG_BIT = 16
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output port_cmd_t         cmd_o
);
  logic wr;
  assign wr = sel_i & we_i;

  always_comb begin
    cmd_o          = '0;
    cmd_o.clr_en   = wr & wdata_i[CONN_BIT];
    cmd_o.set_en   = wr & wdata_i[EN_BIT];
    cmd_o.set_susp = wr & wdata_i[SUSP_BIT];
    cmd_o.clr_chg  = wr & wdata_i[CHG_BIT];
  end
endmodule

// File: rtl/rh_port_evt.sv
module rh_port_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hub_rst_i,
  input  logic connect_i,
  output logic attach_o,
  output logic detach_o
);
  logic conn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conn_q <= 1'b0;
    else         conn_q <= connect_i;
  end

  // edges are discarded while the hub reset rewrites connect status
  assign attach_o = ~hub_rst_i & connect_i & ~conn_q;
  assign detach_o = ~hub_rst_i & ~connect_i & conn_q;
endmodule

// File: rtl/rh_port_stat.sv
module rh_port_stat
  import rh_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hub_rst_i,
  input  logic       fixed_dev_i,
  input  logic       attach_i,
  input  logic       detach_i,
  input  logic       port_rst_done_i,
  input  logic       resume_done_i,
  input  port_cmd_t  cmd_i,
  output port_stat_t st_o
);
  port_stat_t st_q, st_d;
  logic       res_end;

  assign res_end = resume_done_i & st_q.susp;

  always_comb begin
    st_d = st_q;
    if (hub_rst_i) begin
      st_d.conn = fixed_dev_i;
      st_d.en   = 1'b0;
      st_d.susp = 1'b0;
      st_d.chg  = 1'b0;
    end else begin
      // connect status: hardware only
      if (detach_i)      st_d.conn = 1'b0;
      else if (attach_i) st_d.conn = 1'b1;

      // enable: hardware events first
      if (detach_i)                        st_d.en = 1'b0;
      else if (port_rst_done_i || res_end) st_d.en = 1'b1;
      else if (cmd_i.clr_en)               st_d.en = 1'b0;
      else if (cmd_i.set_en && st_q.conn)  st_d.en = 1'b1;

      // suspend
      if (detach_i)                          st_d.susp = 1'b0;
      else if (port_rst_done_i || res_end)   st_d.susp = 1'b0;
      else if (cmd_i.set_susp && st_q.conn)  st_d.susp = 1'b1;

      // connect status change
      if (attach_i || detach_i)                  st_d.chg = 1'b1;
      else if (cmd_i.set_susp && !st_q.conn)     st_d.chg = 1'b1;
      else if (cmd_i.clr_chg)                    st_d.chg = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  assert_detach_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_i |=> (!st_q.conn && !st_q.en && !st_q.susp));

  assert_susp_needs_conn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q.susp) |-> $past(st_q.conn));

  assert_empty_susp_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.set_susp && !st_q.conn && !hub_rst_i) |=> st_q.chg);

  assert_en_needs_conn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q.en) |-> $past(st_q.conn || port_rst_done_i || resume_done_i));

  assert_conn_hw_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(st_q.conn) |-> $past(hub_rst_i || attach_i || detach_i));

  assert_resume_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_done_i && st_q.susp && !hub_rst_i && !detach_i) |=> (st_q.en && !st_q.susp));

  assert_chg_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_q.chg) |-> $past(cmd_i.clr_chg || hub_rst_i));

  assert_hw_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((attach_i || detach_i) && cmd_i.clr_chg) |=> st_q.chg);
endmodule

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rh_port_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHG_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              connect_i,
  input  logic              fixed_dev_i,
  input  logic              hub_rst_i,
  input  logic              port_rst_done_i,
  input  logic              resume_done_i
);
  port_cmd_t  cmd;
  port_stat_t st;
  logic       attach, detach;

  rh_port_cmd #(.DATA_W(DATA_W), .CHG_BIT(CHG_BIT)) u_cmd (
    .sel_i   (sel_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  rh_port_evt u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hub_rst_i (hub_rst_i),
    .connect_i (connect_i),
    .attach_o  (attach),
    .detach_o  (detach)
  );

  rh_port_stat u_stat (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .hub_rst_i       (hub_rst_i),
    .fixed_dev_i     (fixed_dev_i),
    .attach_i        (attach),
    .detach_i        (detach),
    .port_rst_done_i (port_rst_done_i),
    .resume_done_i   (resume_done_i),
    .cmd_i           (cmd),
    .st_o            (st)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o[CONN_BIT] = st.conn;
      rdata_o[EN_BIT]   = st.en;
      rdata_o[SUSP_BIT] = st.susp;
      rdata_o[CHG_BIT]  = st.chg;
    end
  end

  assert_unsel_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (rdata_o == '0));
endmodule

// File: tb/tb_rh_port_ctrl.sv
module tb_rh_port_ctrl;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b1, we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          conn_in = 1'b0, fixed = 1'b0, hrst = 1'b0, prd = 1'b0, rsd = 1'b0;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rh_port_ctrl #(.DATA_W(DW), .CHG_BIT(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .connect_i(conn_in), .fixed_dev_i(fixed), .hub_rst_i(hrst),
    .port_rst_done_i(prd), .resume_done_i(rsd)
  );

  // behavioural reference model
  bit m_c, m_e, m_s, m_g, m_line;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c <= 0; m_e <= 0; m_s <= 0; m_g <= 0; m_line <= 0;
    end else begin
      bit wr, nc, ne, ns, ng, up, dn;
      wr = sel && we;
      nc = m_c; ne = m_e; ns = m_s; ng = m_g;
      up = !hrst && conn_in && !m_line;
      dn = !hrst && !conn_in && m_line;
      if (hrst) begin
        nc = fixed; ne = 0; ns = 0; ng = 0;
      end else begin
        if (wr && wdata[16]) ng = 0;
        if (wr && wdata[2]) begin
          if (m_c) ns = 1; else ng = 1;
        end
        if (wr && wdata[1] && m_c) ne = 1;
        if (wr && wdata[0]) ne = 0;
        if (prd) begin ns = 0; ne = 1; end
        if (rsd && m_s) begin ns = 0; ne = 1; end
        if (up) begin nc = 1; ng = 1; end
        if (dn) begin nc = 0; ne = 0; ns = 0; ng = 1; end
      end
      m_c <= nc; m_e <= ne; m_s <= ns; m_g <= ng;
      m_line <= conn_in;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_word();
    logic [DW-1:0] w;
    w = '0;
    if (sel) begin
      w[0] = m_c; w[1] = m_e; w[2] = m_s; w[16] = m_g;
    end
    return w;
  endfunction

  // one clock, then compare with the model away from the edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("model", rdata, model_word());
  endtask

  task automatic wr(input logic [DW-1:0] d);
    we = 1; wdata = d;
    cyc();
    we = 0; wdata = '0;
  endtask

  task automatic pulse_prd(); prd = 1; cyc(); prd = 0; endtask
  task automatic pulse_rsd(); rsd = 1; cyc(); rsd = 0; endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", rdata, 32'h0);
    rst_n = 1;
    cyc();
    chk("R1 after release", rdata, 32'h0);

    // suspend request on empty port
    wr(32'h4);
    chk("R5 suspend on empty port", rdata, 32'h0001_0000);
    // enable request on empty port
    wr(32'h2);
    chk("R6 enable on empty port", rdata, 32'h0001_0000);
    wr(32'h0);
    chk("R10 write zero keeps change", rdata, 32'h0001_0000);
    wr(32'h0001_0000);
    chk("R10 clear change", rdata, 32'h0);

    // attach
    conn_in = 1; cyc();
    chk("R2 attach", rdata, 32'h0001_0001);
    cyc();
    wr(32'h0001_0000);
    wr(32'h2);
    chk("R6 enable while connected", rdata, 32'h3);
    wr(32'h1);
    chk("R7 clear enable, connect kept", rdata, 32'h1);
    wr(32'h2);
    wr(32'h4);
    chk("R4 suspend while connected", rdata, 32'h7);
    wr(32'h0);
    chk("R4 write zero keeps suspend", rdata, 32'h7);

    // resume completion with enable already cleared
    wr(32'h1);
    chk("R7 clear enable while suspended", rdata, 32'h5);
    pulse_rsd();
    chk("R9 resume end", rdata, 32'h3);
    wr(32'h1);
    pulse_rsd();
    chk("R9 resume ignored when not suspended", rdata, 32'h1);

    // reset completion during suspend
    wr(32'h4);
    chk("R4 suspend again", rdata, 32'h5);
    pulse_prd();
    chk("R8 reset end", rdata, 32'h3);

    // unselected access
    sel = 0; we = 1; wdata = 32'h0000_0003;
    cyc();
    chk("R1 unselected read", rdata, 32'h0);
    we = 0; wdata = '0; sel = 1;
    cyc();
    chk("R1 unselected write ignored", rdata, 32'h3);

    // disconnect colliding with enable and suspend requests
    wr(32'h4);
    conn_in = 0; we = 1; wdata = 32'h6;
    cyc();
    we = 0; wdata = '0;
    chk("R3 R12 disconnect beats writes", rdata, 32'h0001_0000);

    // attach colliding with change clear
    conn_in = 1; we = 1; wdata = 32'h0001_0000;
    cyc();
    we = 0; wdata = '0;
    chk("R12 attach beats change clear", rdata, 32'h0001_0001);
    conn_in = 0; cyc();
    chk("R2 detach", rdata, 32'h0001_0000);

    // hub reset with non-removable device
    fixed = 1; hrst = 1; cyc(); hrst = 0;
    chk("R11 hub reset fixed device", rdata, 32'h1);
    fixed = 0; hrst = 1; cyc(); hrst = 0;
    chk("R11 hub reset removable", rdata, 32'h0);

    // pattern sweep against the model
    for (int i = 0; i < 64; i++) begin
      conn_in = i[3] ^ i[1];
      we = i[0];
      wdata = {15'h0, i[2], 13'h0, i[4], i[5], i[1]};
      prd = (i % 11) == 5;
      rsd = (i % 7) == 3;
      cyc();
    end
    we = 0; prd = 0; rsd = 0;
    cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule